// File: doc/BRIEF.md
# Four-operation arithmetic logic unit

A purely combinational unit that takes two unsigned or two's-complement operands of a parameterised width and returns one of four results, chosen by a two-bit select. The four results are the sum, the difference (first operand minus second), the bitwise NAND and the bitwise NOR. Subtraction uses the same adder as addition. The second operand is inverted and a carry of one is injected, so only one carry chain exists.

Each result comes with three flags: a carry-out, a signed overflow indication and a zero indication. A surrounding datapath uses them for unsigned compare, signed range checks and branch-on-zero. The width defaults to 8 bits.

Top module: `alu_nn4`

## Requirements
- R1: With select 2'b00, `res` equals (A + B) modulo 2^W and `carry_out` equals bit W of the full sum.
- R2: With select 2'b01, `res` equals (A - B) modulo 2^W and `carry_out` is 1 exactly when A >= B as unsigned values, meaning no borrow.
- R3: With select 2'b10, `res` equals the bitwise NAND of A and B.
- R4: With select 2'b11, `res` equals the bitwise NOR of A and B.
- R5: With select 2'b00, `ovf` is 1 exactly when the signed sum of A and B lies outside the W-bit two's-complement range.
- R6: With select 2'b01, `ovf` is 1 exactly when the signed difference A - B lies outside the W-bit two's-complement range.
- R7: With select 2'b10 or 2'b11, both `carry_out` and `ovf` are 0 whatever the operands are.
- R8: For every select value, `zero` is 1 exactly when all W bits of `res` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | W | First operand (minuend for subtraction) |
| op_b | input | W | Second operand (subtrahend for subtraction) |
| op_sel | input | 2 | 00 add, 01 subtract, 10 NAND, 11 NOR |
| res | output | W | Selected result |
| carry_out | output | 1 | Adder carry; no-borrow for subtract; 0 for logic |
| ovf | output | 1 | Signed overflow; 0 for logic |
| zero | output | 1 | All result bits are zero |

## Verification
The block holds no state. A fault in the operand inversion or in the carry injection therefore shows at once, in the same evaluation, as a result that is off by one or bitwise wrong for subtraction, and as a reversed no-borrow carry. Overflow faults show only near the sign boundaries. For that reason the corner table places operands at 0x7F, 0x80, 0xFF and 0x00. These values also expose a flag that fails to clear for the logic operations.

// File: rtl/alu_nn4.sv
module alu_nn4 #(
  parameter int W = 8
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [1:0]   op_sel,
  output logic [W-1:0] res,
  output logic         carry_out,
  output logic         ovf,
  output logic         zero
);
  localparam logic [1:0] SEL_ADD  = 2'b00;
  localparam logic [1:0] SEL_SUB  = 2'b01;
  localparam logic [1:0] SEL_NAND = 2'b10;
  localparam logic [1:0] SEL_NOR  = 2'b11;

  logic         is_sub;
  logic         is_logic;
  logic [W-1:0] b_eff;
  logic [W:0]   sum_full;
  logic [W-1:0] logic_res;

  assign is_sub    = (op_sel == SEL_SUB);
  assign is_logic  = op_sel[1];
  assign b_eff     = op_b ^ {W{is_sub}};
  assign sum_full  = {1'b0, op_a} + {1'b0, b_eff} + {{W{1'b0}}, is_sub};
  assign logic_res = (op_sel == SEL_NOR) ? ~(op_a | op_b) : ~(op_a & op_b);

  assign res       = is_logic ? logic_res : sum_full[W-1:0];
  assign carry_out = ~is_logic & sum_full[W];
  assign ovf       = ~is_logic & (op_a[W-1] == b_eff[W-1]) & (sum_full[W-1] != op_a[W-1]);
  assign zero      = ~|res;

  logic signed [W+1:0] s_add;
  logic signed [W+1:0] s_sub;
  logic signed [W+1:0] s_max;
  logic signed [W+1:0] s_min;
  assign s_add = $signed({{2{op_a[W-1]}}, op_a}) + $signed({{2{op_b[W-1]}}, op_b});
  assign s_sub = $signed({{2{op_a[W-1]}}, op_a}) - $signed({{2{op_b[W-1]}}, op_b});
  assign s_max = $signed({3'b000, {(W-1){1'b1}}});
  assign s_min = -s_max - 1;

  always_comb begin
    if (op_sel == SEL_ADD) begin
      AST_ADD_SUM: assert ({carry_out, res} == ({1'b0, op_a} + {1'b0, op_b})); // R1
      AST_ADD_OVF: assert (ovf == ((s_add > s_max) || (s_add < s_min))); // R5
    end
    if (op_sel == SEL_SUB) begin
      AST_SUB_NOBORROW: assert (carry_out == (op_a >= op_b)); // R2
      AST_SUB_OVF: assert (ovf == ((s_sub > s_max) || (s_sub < s_min))); // R6
    end
    if (op_sel == SEL_NAND) begin
      AST_NAND_BITS: assert (((res & op_a & op_b) == '0) && ((res | (op_a & op_b)) == '1)); // R3
    end
    if (op_sel == SEL_NOR) begin
      AST_NOR_BITS: assert (((res & (op_a | op_b)) == '0) && ((res | op_a | op_b) == '1)); // R4
    end
    if (is_logic) begin
      AST_LOGIC_FLAGS: assert (!carry_out && !ovf); // R7
    end
    AST_ZERO_MATCH: assert (zero == (res == '0)); // R8
  end
endmodule

// File: tb/test_alu_nn4.sv
module test_alu_nn4;
  localparam int W = 8;
  localparam int NV = 20;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [W-1:0] op_a, op_b, res;
  logic [1:0]   op_sel;
  logic         carry_out, ovf, zero;

  alu_nn4 #(.W(W)) i_alu_nn4 (
    .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
    .res(res), .carry_out(carry_out), .ovf(ovf), .zero(zero)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  localparam logic [17:0] VEC [NV] = '{
    {2'b00, 8'h00, 8'h00}, {2'b00, 8'hFF, 8'h01}, {2'b00, 8'h7F, 8'h01},
    {2'b00, 8'h80, 8'h80}, {2'b00, 8'h80, 8'h7F}, {2'b00, 8'h12, 8'h34},
    {2'b01, 8'h80, 8'h01}, {2'b01, 8'h00, 8'h01}, {2'b01, 8'h55, 8'h55},
    {2'b01, 8'h7F, 8'hFF}, {2'b01, 8'h01, 8'h80}, {2'b01, 8'hFF, 8'hFE},
    {2'b10, 8'hFF, 8'hFF}, {2'b10, 8'hAA, 8'h55}, {2'b10, 8'hF0, 8'h3C},
    {2'b10, 8'h00, 8'h00}, {2'b11, 8'h00, 8'h00}, {2'b11, 8'hAA, 8'h55},
    {2'b11, 8'hFF, 8'h00}, {2'b11, 8'h0F, 8'h0C}
  };

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s sel=%0d a=%h b=%h actual=%0h expected=%0h", tag, op_sel, op_a, op_b, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] s, input logic [W-1:0] a, input logic [W-1:0] b);
    int ia, ib, sa, sb, v, e_res, e_c, e_o;
    @(negedge clk);
    op_sel = s; op_a = a; op_b = b;
    #1;
    ia = int'(a); ib = int'(b);
    sa = (ia > 127) ? ia - 256 : ia;
    sb = (ib > 127) ? ib - 256 : ib;
    e_c = 0; e_o = 0;
    case (s)
      2'b00: begin
        v = ia + ib; e_res = v % 256; e_c = v / 256;
        e_o = ((sa + sb) > 127 || (sa + sb) < -128) ? 1 : 0;
        check("R1 res", int'(res), e_res);
        check("R1 carry", int'(carry_out), e_c);
        check("R5 ovf", int'(ovf), e_o);
      end
      2'b01: begin
        e_res = (ia - ib + 256) % 256; e_c = (ia >= ib) ? 1 : 0;
        e_o = ((sa - sb) > 127 || (sa - sb) < -128) ? 1 : 0;
        check("R2 res", int'(res), e_res);
        check("R2 carry", int'(carry_out), e_c);
        check("R6 ovf", int'(ovf), e_o);
      end
      2'b10: begin
        e_res = 255 - (ia & ib);
        check("R3 res", int'(res), e_res);
        check("R7 carry", int'(carry_out), 0);
        check("R7 ovf", int'(ovf), 0);
      end
      default: begin
        e_res = 255 - (ia | ib);
        check("R4 res", int'(res), e_res);
        check("R7 carry", int'(carry_out), 0);
        check("R7 ovf", int'(ovf), 0);
      end
    endcase
    check("R8 zero", int'(zero), (e_res == 0) ? 1 : 0);
  endtask

  initial begin
    op_sel = 2'b00; op_a = '0; op_b = '0;
    #1;
    check("R8 initial zero", int'(zero), 1);
    check("R1 initial res", int'(res), 0);
    for (int i = 0; i < NV; i++) apply(VEC[i][17:16], VEC[i][15:8], VEC[i][7:0]);
    for (int i = 0; i < 400; i++) apply(2'($urandom), 8'($urandom), 8'($urandom));
    apply(2'b01, 8'h80, 8'h7F);   // R6 negative minus positive overflows
    apply(2'b00, 8'hFF, 8'hFF);   // R1 carry with wrap
    apply(2'b00, 8'h01, 8'hFF);   // R8 zero from carry wrap
    apply(2'b10, 8'h80, 8'h80);   // R7 operands that would overflow
    apply(2'b11, 8'h7F, 8'h80);   // R8 zero on NOR
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule